// File: doc/BRIEF.md
# Join Counter Synchronization Unit

This block settles n-way join synchronization for a message-handling coprocessor, so the data processor never runs the join itself. Each join request carries a frame pointer, a counter offset inside that frame, an unsigned 8-bit terminal count and a continuation instruction pointer. The unit reads the counter word at the frame pointer plus the offset in a small local counter memory, adds one, compares the result with the terminal count and writes the word back. It does all of this in the same clock edge as the accept, so the update is atomic.

Arrivals that fall short of the terminal count store the new value and then end. The final arrival writes the counter back to zero and posts the pair <frame pointer, instruction pointer> into a 16-entry continuation FIFO. The data processor pops the FIFO with a "next" request. A second port lets the data processor read or write any counter word directly, for example to check progress or to clear a counter.

Top module: `join_counter_unit`

## Requirements
- R1: An accepted join adds one to the counter word at address (join_fp + join_off) taken modulo 2^8 and then reduced to its low 4 bits. Reading that address through the direct port afterwards returns the new value.
- R2: When the incremented value is greater than or equal to join_term, the word is written to zero and {join_fp, join_ip} is pushed into the continuation FIFO.
- R3: When the incremented value is below join_term, the incremented value is stored and nothing is pushed, so cont_empty does not change.
- R4: With terminal count c and a counter starting at zero, the first c-1 joins push nothing and the c-th join pushes. A terminal count of 1 pushes on every join.
- R5: Joins to the same address that are accepted on consecutive cycles each see the previous update, so two back-to-back joins raise the counter by two.
- R6: While cont_empty is 0, cont_fp and cont_ip show the oldest continuation. next_req pops it, so entries come out in push order. next_req while cont_empty is 1 has no effect.
- R7: The FIFO holds 16 entries; cont_full is 1 exactly when 16 are held and cont_empty exactly when none are held. A join that would push while the FIFO is full and next_req is 0 is held off (join_ready is 0) and its counter is untouched. If next_req is 1 in that cycle, the join is accepted together with the pop.
- R8: A direct write sets a counter word to dir_wdata. A direct read returns the word on dir_rdata on the cycle after the request. While dir_valid is 1, join_ready is 0.
- R9: After reset, every counter is zero, cont_empty is 1, cont_full is 0 and join_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| join_valid | input | 1 | Join request present |
| join_ready | output | 1 | Join accepted on this edge when join_valid is 1 |
| join_fp | input | 8 | Frame pointer |
| join_off | input | 4 | Counter offset within the frame |
| join_term | input | 8 | Terminal count |
| join_ip | input | 8 | Continuation instruction pointer |
| next_req | input | 1 | Pop the oldest continuation |
| cont_fp | output | 8 | Frame pointer of the oldest continuation |
| cont_ip | output | 8 | Instruction pointer of the oldest continuation |
| cont_empty | output | 1 | FIFO holds no continuation |
| cont_full | output | 1 | FIFO holds 16 continuations |
| dir_valid | input | 1 | Direct counter access |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | 4 | Direct access counter address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data, one cycle after the request |

## Verification
The interaction that matters is a final join arriving in the same cycle as a "next" pop while the FIFO is full. The bench fills the FIFO with sixteen terminal-count-1 posts and loads a counter so that the next join will post. It then shows that the join is held off, with the counter unchanged on a direct read. Finally it presents the join together with next_req and expects acceptance, a popped head matching the scoreboard, the flag still full, and the new continuation at the tail of the drain order.

// File: rtl/jcu_pkg.sv
package jcu_pkg;
    parameter int FP_W       = 8;
    parameter int IP_W       = 8;
    parameter int CNT_W      = 8;
    parameter int CNT_DEPTH  = 16;
    parameter int FIFO_DEPTH = 16;

    localparam int ADDR_W  = $clog2(CNT_DEPTH);
    localparam int FPTR_W  = $clog2(FIFO_DEPTH);
    localparam int FCNT_W  = FPTR_W + 1;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [FP_W-1:0] fp;
        logic [IP_W-1:0] ip;
    } cont_t;

    function automatic addr_t frame_addr(logic [FP_W-1:0] fp, addr_t off);
        logic [FP_W-1:0] sum;
        sum = fp + FP_W'(off);
        return sum[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/jcu_counter_ram.sv
module jcu_counter_ram
    import jcu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t join_addr,
    output cnt_t  join_rdata,
    input  logic  dir_rd,
    input  addr_t dir_addr,
    output cnt_t  dir_rdata,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  cnt_t  wr_data
);
    cnt_t mem [CNT_DEPTH];
    cnt_t rd_q;

    assign join_rdata = mem[join_addr];
    assign dir_rdata  = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CNT_DEPTH; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            if (dir_rd) rd_q <= mem[dir_addr];
        end
    end
endmodule

// File: rtl/jcu_update.sv
module jcu_update
    import jcu_pkg::*;
(
    input  cnt_t cur_cnt,
    input  cnt_t term,
    output logic reached,
    output cnt_t new_cnt
);
    logic [CNT_W:0] inc;

    always_comb begin
        inc     = {1'b0, cur_cnt} + {{CNT_W{1'b0}}, 1'b1};
        reached = (inc >= {1'b0, term});
        new_cnt = reached ? '0 : inc[CNT_W-1:0];
    end
endmodule

// File: rtl/jcu_cont_fifo.sv
module jcu_cont_fifo
    import jcu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  cont_t push_data,
    input  logic  pop,
    output cont_t head,
    output logic  empty,
    output logic  full
);
    cont_t               slots [FIFO_DEPTH];
    logic [FPTR_W-1:0]   wr_ptr, rd_ptr;
    logic [FCNT_W-1:0]   count;
    logic                do_pop;

    assign empty  = (count == '0);
    assign full   = (count == FCNT_W'(FIFO_DEPTH));
    assign head   = slots[rd_ptr];
    assign do_pop = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + FCNT_W'(push) - FCNT_W'(do_pop);
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |-> !push);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= FCNT_W'(FIFO_DEPTH));

    assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/join_counter_unit.sv
module join_counter_unit
    import jcu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  join_valid,
    output logic                  join_ready,
    input  logic [FP_W-1:0]       join_fp,
    input  logic [ADDR_W-1:0]     join_off,
    input  logic [CNT_W-1:0]      join_term,
    input  logic [IP_W-1:0]       join_ip,
    input  logic                  next_req,
    output logic [FP_W-1:0]       cont_fp,
    output logic [IP_W-1:0]       cont_ip,
    output logic                  cont_empty,
    output logic                  cont_full,
    input  logic                  dir_valid,
    input  logic                  dir_we,
    input  logic [ADDR_W-1:0]     dir_addr,
    input  logic [CNT_W-1:0]      dir_wdata,
    output logic [CNT_W-1:0]      dir_rdata
);
    addr_t jaddr;
    cnt_t  jcur, jnew, wdata;
    logic  reached, join_fire, push, wen;
    addr_t waddr;
    cont_t head, entry;

    assign jaddr = frame_addr(join_fp, join_off);

    jcu_counter_ram u_ram (
        .clk        (clk),
        .rst        (rst),
        .join_addr  (jaddr),
        .join_rdata (jcur),
        .dir_rd     (dir_valid && !dir_we),
        .dir_addr   (dir_addr),
        .dir_rdata  (dir_rdata),
        .wr_en      (wen),
        .wr_addr    (waddr),
        .wr_data    (wdata)
    );

    jcu_update u_upd (
        .cur_cnt (jcur),
        .term    (join_term),
        .reached (reached),
        .new_cnt (jnew)
    );

    assign join_ready = !dir_valid && !(reached && cont_full && !next_req);
    assign join_fire  = join_valid && join_ready;
    assign push       = join_fire && reached;
    assign entry      = '{fp: join_fp, ip: join_ip};

    always_comb begin
        wen   = 1'b0;
        waddr = jaddr;
        wdata = jnew;
        if (dir_valid) begin
            wen   = dir_we;
            waddr = dir_addr;
            wdata = dir_wdata;
        end else if (join_fire) begin
            wen = 1'b1;
        end
    end

    jcu_cont_fifo u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (entry),
        .pop       (next_req),
        .head      (head),
        .empty     (cont_empty),
        .full      (cont_full)
    );

    assign cont_fp = head.fp;
    assign cont_ip = head.ip;

    assert_increment_stored_R3: assert property (@(posedge clk) disable iff (rst)
        (join_fire && !reached) |=>
            u_ram.mem[$past(jaddr)] == $past(jcur) + 1'b1);

    assert_clear_on_post_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> (u_ram.mem[$past(jaddr)] == '0) && !cont_empty);

    assert_direct_priority_R8: assert property (@(posedge clk) disable iff (rst)
        dir_valid |-> !join_ready);

    assert_stall_keeps_count_R7: assert property (@(posedge clk) disable iff (rst)
        (join_valid && !join_ready && !dir_valid) |=>
            u_ram.mem[$past(jaddr)] == $past(jcur));
endmodule

// File: tb/join_counter_unit_bench.sv
`timescale 1ns/1ps
module join_counter_unit_bench;
    logic       clk = 0, rst = 1;
    logic       join_valid = 0, next_req = 0;
    logic       join_ready;
    logic [7:0] join_fp = 0, join_term = 0, join_ip = 0;
    logic [3:0] join_off = 0, dir_addr = 0;
    logic [7:0] cont_fp, cont_ip, dir_wdata = 0, dir_rdata;
    logic       cont_empty, cont_full, dir_valid = 0, dir_we = 0;

    int n_checks = 0, n_fail = 0;
    logic [15:0] exp_q [$];
    logic [7:0]  model [16];
    bit          done = 0;

    always #2 clk = ~clk;

    join_counter_unit u_join_counter_unit (.*);

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares every popped head against the scoreboard.
    always @(negedge clk) begin
        if (!rst && next_req && !cont_empty) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 actual=%0h expected=none", {cont_fp, cont_ip});
            end else begin
                if ({cont_fp, cont_ip} != exp_q[0]) begin
                    n_fail++;
                    $display("FAIL R6 actual=%0h expected=%0h", {cont_fp, cont_ip}, exp_q[0]);
                end
                void'(exp_q.pop_front());
            end
        end
    end

    function automatic logic [3:0] addr_of(logic [7:0] fp, logic [3:0] off);
        logic [7:0] s = fp + {4'd0, off};
        return s[3:0];
    endfunction

    task automatic model_join(logic [7:0] fp, logic [3:0] off, logic [7:0] term, logic [7:0] ip);
        logic [3:0] a = addr_of(fp, off);
        int inc = model[a] + 1;
        if (inc >= term) begin
            exp_q.push_back({fp, ip});
            model[a] = 0;
        end else model[a] = inc[7:0];
    endtask

    // Driver: one join, waits for acceptance.
    task automatic do_join(logic [7:0] fp, logic [3:0] off, logic [7:0] term, logic [7:0] ip);
        join_fp = fp; join_off = off; join_term = term; join_ip = ip; join_valid = 1;
        #1;
        while (!join_ready) begin @(negedge clk); #1; end
        model_join(fp, off, term, ip);
        @(posedge clk);
        @(negedge clk);
        join_valid = 0;
    endtask

    task automatic dir_read(logic [3:0] a, output logic [7:0] v);
        dir_valid = 1; dir_we = 0; dir_addr = a;
        @(posedge clk); @(negedge clk);
        dir_valid = 0;
        v = dir_rdata;
    endtask

    task automatic dir_write(logic [3:0] a, logic [7:0] d);
        dir_valid = 1; dir_we = 1; dir_addr = a; dir_wdata = d;
        @(posedge clk); @(negedge clk);
        dir_valid = 0; dir_we = 0;
        model[a] = d;
    endtask

    task automatic pop_one();
        next_req = 1;
        @(posedge clk); @(negedge clk);
        next_req = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 16; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check("R9 empty", cont_empty, 1);
        check("R9 full", cont_full, 0);
        check("R9 ready", join_ready, 1);
        dir_read(4'd3, v); check("R9 counter zero", v, 0);

        // R6 next when empty has no effect
        pop_one();
        check("R6 empty stays", cont_empty, 1);

        // R4 terminal count 3 at addr 0x12 -> 2
        do_join(8'h10, 4'd2, 8'd3, 8'hA1);
        check("R3 no post", cont_empty, 1);
        dir_read(4'd2, v); check("R1 count 1", v, 1);
        do_join(8'h10, 4'd2, 8'd3, 8'hA1);
        dir_read(4'd2, v); check("R3 count 2", v, 2);
        check("R4 still empty", cont_empty, 1);
        do_join(8'h10, 4'd2, 8'd3, 8'hA1);
        check("R4 posted", cont_empty, 0);
        check("R6 head fp", cont_fp, 8'h10);
        check("R6 head ip", cont_ip, 8'hA1);
        dir_read(4'd2, v); check("R2 cleared", v, 0);
        pop_one();
        check("R6 empty after pop", cont_empty, 1);

        // R4 terminal count 1 posts every join; address wrap R1
        do_join(8'hFE, 4'd3, 8'd1, 8'h11);
        do_join(8'hFE, 4'd3, 8'd1, 8'h12);
        dir_read(4'd1, v); check("R1 wrapped addr zero", v, 0);
        pop_one(); pop_one();
        check("R4 both popped", cont_empty, 1);

        // R5 back-to-back joins same address
        join_fp = 8'h20; join_off = 4'd7; join_term = 8'd5; join_ip = 8'h33; join_valid = 1;
        model_join(8'h20, 4'd7, 8'd5, 8'h33);
        model_join(8'h20, 4'd7, 8'd5, 8'h33);
        @(posedge clk); @(posedge clk); @(negedge clk);
        join_valid = 0;
        dir_read(4'd7, v); check("R5 two increments", v, 2);

        // R8 direct write then join reaches terminal
        dir_write(4'd5, 8'd4);
        dir_read(4'd5, v); check("R8 direct write", v, 4);
        do_join(8'h05, 4'd0, 8'd3, 8'h44);
        check("R2 post above term", cont_empty, 0);
        dir_read(4'd5, v); check("R2 cleared after post", v, 0);
        pop_one();

        // R7 fill FIFO then stall
        for (int i = 0; i < 16; i++) do_join(8'(i), 4'd8, 8'd1, 8'(8'h80 + i));
        check("R7 full", cont_full, 1);
        dir_write(4'd9, 8'd1);
        join_fp = 8'h09; join_off = 4'd0; join_term = 8'd2; join_ip = 8'hEE; join_valid = 1;
        #1; check("R7 stalled", join_ready, 0);
        @(posedge clk); @(negedge clk);
        join_valid = 0;
        dir_read(4'd9, v); check("R7 count untouched", v, 1);
        // join with simultaneous pop
        join_valid = 1; next_req = 1;
        #1; check("R7 accepted with pop", join_ready, 1);
        model_join(8'h09, 4'd0, 8'd2, 8'hEE);
        @(posedge clk); @(negedge clk);
        join_valid = 0; next_req = 0;
        check("R7 still full", cont_full, 1);
        for (int i = 0; i < 16; i++) pop_one();
        check("R7 drained", cont_empty, 1);
        check("R6 scoreboard empty", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule